// File: doc/BRIEF.md
# Daisy-Chain Vectored Interrupt Arbiter

This block sits between a row of interrupting device slots and a processor. Each slot raises a request, which is caught in a pending flag. The processor sees a single active-low request line. The line goes low as soon as any flag is set, and it returns high once every flag has been serviced.

When the processor raises its acknowledge, the acknowledge travels through a serial chain of slot stages. Slot 0 receives it first. A stage with nothing pending passes the acknowledge on. A stage with a pending flag keeps the acknowledge and blocks every stage after it. The one stage that receives the acknowledge and does not pass it on is the winner, and its programmed vector is driven on the data output. When the processor lowers its acknowledge, the winner's pending flag is cleared and the next request can be served.

The vector of each slot is held in a register. Software writes it through a small configuration port that carries a slot index, the data and a write enable.

Top module: `irq_chain_arbiter`

## Requirements
- R1: A high `req_i[k]` sampled at a rising clock edge sets pending flag k. `irq_no` is low in the cycle after that edge whenever any flag is set, and high when no flag is set.
- R2: While `ack_i` is high, the pending slot with the lowest index wins. Slot 0 has the highest priority and priority falls with the index.
- R3: While a slot wins, `vec_o` equals that slot's programmed vector and `vec_valid_o` is 1. Both follow `ack_i` in the same cycle, without a clock edge in between.
- R4: While `ack_i` is low, or no flag is pending, `vec_o` is 0 and `vec_valid_o` is 0.
- R5: A clock edge that samples `ack_i` low after the previous edge sampled it high clears the flag of the slot that won at that previous edge. No other flag changes because of this. As long as `ack_i` stays high, no flag is cleared.
- R6: At a clearing edge the clear takes precedence over a request that is still high. If the request is still high, it sets the flag again at the following edge, so `irq_no` is high for exactly one cycle.
- R7: If a higher-priority slot becomes pending while `ack_i` is high, it takes over as winner after the edge that latches it. The clear then applies to that slot, and the slot that lost stays pending.
- R8: A rising edge with `cfg_we_i` high stores `cfg_vec_i` into the vector of slot `cfg_idx_i`. While `cfg_we_i` is low, `cfg_vec_i` has no effect.
- R9: An active `rst_ni` clears all pending flags and sets all vectors to 0, so `irq_no` reads high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_SLOTS | Request inputs, one per slot, index 0 first in the chain |
| ack_i | input | 1 | Acknowledge from the processor, enters the chain at slot 0 |
| cfg_we_i | input | 1 | Vector write enable |
| cfg_idx_i | input | IDX_W | Slot index for a vector write |
| cfg_vec_i | input | VEC_W | Vector data for a write |
| irq_no | output | 1 | Shared request line, active low |
| vec_o | output | VEC_W | Vector of the winning slot, 0 if there is no winner |
| vec_valid_o | output | 1 | High while a slot wins |

## Verification
A pending flag that is stuck or lost shows on `irq_no` in the cycle after the edge involved. A lost flag also shows as a vector that is missing from the service sequence. An error in the chain logic puts the wrong vector on `vec_o` at once, as soon as `ack_i` rises. If the delay stage on the acknowledge or the registered winner is wrong, the wrong flag is cleared. That error shows at the next acknowledge, or as `irq_no` staying low after all slots have been served. Each case is reached directly by a short pulse pattern, so a fault shows within a few cycles of its cause.

// File: rtl/irq_chain_pkg.sv
`timescale 1ns/1ps
package irq_chain_pkg;
  localparam int unsigned DEF_SLOTS = 4;
  localparam int unsigned DEF_VEC_W = 8;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/irq_vec_regs.sv
`timescale 1ns/1ps
module irq_vec_regs #(
  parameter int unsigned NUM_SLOTS = irq_chain_pkg::DEF_SLOTS,
  parameter int unsigned VEC_W     = irq_chain_pkg::DEF_VEC_W,
  parameter int unsigned IDX_W     = irq_chain_pkg::idx_width(NUM_SLOTS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [IDX_W-1:0]           idx_i,
  input  logic [VEC_W-1:0]           data_i,
  output logic [NUM_SLOTS*VEC_W-1:0] vec_flat_o
);
  logic [VEC_W-1:0] vec_q [NUM_SLOTS];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    vec_q[s] <= '0;
      else if (we_i && (idx_i == IDX_W'(s)))          vec_q[s] <= data_i;
    end
    assign vec_flat_o[s*VEC_W +: VEC_W] = vec_q[s];
  end

  // R8
  vec_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (32'(idx_i) < NUM_SLOTS)) |=> (vec_q[$past(idx_i)] == $past(data_i)));
  // R8
  vec_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(vec_flat_o));
endmodule

// File: rtl/irq_chain_link.sv
`timescale 1ns/1ps
module irq_chain_link (
  input  logic pi_i,
  input  logic pend_i,
  output logic po_o,
  output logic win_o
);
  // consume acknowledge when pending, pass it otherwise
  assign po_o  = pi_i & ~pend_i;
  assign win_o = pi_i & pend_i;
endmodule

// File: rtl/irq_pend_latch.sv
`timescale 1ns/1ps
module irq_pend_latch #(
  parameter int unsigned NUM_SLOTS = irq_chain_pkg::DEF_SLOTS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SLOTS-1:0] req_i,
  input  logic                 ack_i,
  input  logic [NUM_SLOTS-1:0] win_i,
  output logic [NUM_SLOTS-1:0] pend_o
);
  logic                 ack_q;
  logic [NUM_SLOTS-1:0] win_q;
  logic [NUM_SLOTS-1:0] pend_q;
  logic [NUM_SLOTS-1:0] clr;
  logic                 ack_fall;

  assign ack_fall = ack_q & ~ack_i;
  assign clr      = ack_fall ? win_q : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q  <= 1'b0;
      win_q  <= '0;
      pend_q <= '0;
    end else begin
      ack_q  <= ack_i;
      win_q  <= win_i;
      pend_q <= (pend_q | req_i) & ~clr; // clear wins over a held request
    end
  end

  assign pend_o = pend_q;

  // R5
  clear_winner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_q && !ack_i) |=> ((pend_q & $past(win_q)) == '0));
  // R5
  ack_high_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> ((($past(pend_q)) & ~pend_q) == '0));
  // R1
  no_spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == '0) |=> ((pend_q & ~$past(pend_q)) == '0));
endmodule

// File: rtl/irq_chain_arbiter.sv
`timescale 1ns/1ps
module irq_chain_arbiter #(
  parameter int unsigned NUM_SLOTS = irq_chain_pkg::DEF_SLOTS,
  parameter int unsigned VEC_W     = irq_chain_pkg::DEF_VEC_W,
  parameter int unsigned IDX_W     = irq_chain_pkg::idx_width(NUM_SLOTS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SLOTS-1:0] req_i,
  input  logic                 ack_i,
  input  logic                 cfg_we_i,
  input  logic [IDX_W-1:0]     cfg_idx_i,
  input  logic [VEC_W-1:0]     cfg_vec_i,
  output logic                 irq_no,
  output logic [VEC_W-1:0]     vec_o,
  output logic                 vec_valid_o
);
  logic [NUM_SLOTS*VEC_W-1:0] slot_vec;
  logic [NUM_SLOTS-1:0]       pend;
  logic [NUM_SLOTS-1:0]       win;
  logic [NUM_SLOTS:0]         pi;
  logic [VEC_W-1:0]           vec_sel;

  irq_vec_regs #(.NUM_SLOTS(NUM_SLOTS), .VEC_W(VEC_W), .IDX_W(IDX_W)) i_vec_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .idx_i      (cfg_idx_i),
    .data_i     (cfg_vec_i),
    .vec_flat_o (slot_vec)
  );

  irq_pend_latch #(.NUM_SLOTS(NUM_SLOTS)) i_pend_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .ack_i  (ack_i),
    .win_i  (win),
    .pend_o (pend)
  );

  assign pi[0] = ack_i;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_link
    irq_chain_link i_link (
      .pi_i   (pi[s]),
      .pend_i (pend[s]),
      .po_o   (pi[s+1]),
      .win_o  (win[s])
    );
  end

  always_comb begin
    vec_sel = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (win[s]) vec_sel = vec_sel | slot_vec[s*VEC_W +: VEC_W];
    end
  end

  assign vec_o       = vec_sel;
  assign vec_valid_o = |win;
  assign irq_no      = ~|pend;

  // R2
  one_winner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(win));
  // R2
  nearest_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win != '0) |-> ((pend & (win - 1'b1)) == '0));
  // R4
  valid_needs_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> ack_i);
  // R4
  idle_no_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_no |-> (!vec_valid_o && (vec_o == '0)));
  // R1
  req_drops_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((req_i != '0) && ack_i) |=> !irq_no);
endmodule

// File: tb/test_irq_chain_arbiter.sv
`timescale 1ns/1ps
module test_irq_chain_arbiter;
  localparam int unsigned N = 4;
  localparam int unsigned W = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic [N-1:0] req_i;
  logic         ack_i;
  logic         cfg_we_i;
  logic [1:0]   cfg_idx_i;
  logic [W-1:0] cfg_vec_i;
  logic         irq_no;
  logic [W-1:0] vec_o;
  logic         vec_valid_o;

  int n_vec = 0;
  int n_err = 0;
  bit done  = 1'b0;
  logic [W-1:0] exp_vec [N];

  localparam logic [N-1:0] MASKS [8] = '{4'b0001, 4'b0110, 4'b1100, 4'b1000,
                                          4'b1111, 4'b1010, 4'b0101, 4'b0000};

  irq_chain_arbiter #(.NUM_SLOTS(N), .VEC_W(W)) i_irq_chain_arbiter (
    .clk_i, .rst_ni, .req_i, .ack_i, .cfg_we_i, .cfg_idx_i, .cfg_vec_i,
    .irq_no, .vec_o, .vec_valid_o
  );

  always #2.5 clk_i = ~clk_i;

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic write_vec(input int k, input logic [W-1:0] v);
    cfg_we_i = 1'b1; cfg_idx_i = 2'(k); cfg_vec_i = v;
    step();
    cfg_we_i = 1'b0;
    exp_vec[k] = v;
  endtask

  task automatic pulse_req(input logic [N-1:0] m);
    req_i = m;
    step();
    req_i = '0;
  endtask

  // serve one slot: raise ack, check vector, drop ack, let clear edge pass
  task automatic serve(input int k, input string tag);
    ack_i = 1'b1; #1;
    chk({tag, " vec"}, 32'(vec_o), 32'(exp_vec[k]));
    chk({tag, " valid"}, 32'(vec_valid_o), 32'd1);
    step();
    ack_i = 1'b0; #1;
    chk("R4 valid low after ack", 32'(vec_valid_o), 32'd0);
    step();
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; req_i = '0; ack_i = 1'b0;
    cfg_we_i = 1'b0; cfg_idx_i = '0; cfg_vec_i = '0;
    step(); step();
    // R9 reset state
    chk("R9 irq_no in reset", 32'(irq_no), 32'd1);
    chk("R9 vec in reset", 32'(vec_o), 32'd0);
    rst_ni = 1'b1;
    step();
    for (int k = 0; k < N; k++) write_vec(k, W'(8'h10 * (k + 1) + k));

    // table walk: R1 R2 R3 R4 R5
    for (int t = 0; t < 8; t++) begin
      pulse_req(MASKS[t]);
      chk("R1 irq_no after request", 32'(irq_no), 32'(MASKS[t] == '0));
      if (MASKS[t] == '0) begin
        ack_i = 1'b1; #1;
        chk("R4 vec with nothing pending", 32'(vec_o), 32'd0);
        chk("R4 valid with nothing pending", 32'(vec_valid_o), 32'd0);
        step();
        ack_i = 1'b0;
        step();
      end else begin
        for (int k = 0; k < N; k++) if (MASKS[t][k]) serve(k, "R2 R3 priority order");
      end
      chk("R5 line high after all served", 32'(irq_no), 32'd1);
    end

    // R5: held acknowledge clears nothing
    pulse_req(4'b0010);
    ack_i = 1'b1;
    step(); step(); step();
    chk("R5 held ack keeps pending", 32'(irq_no), 32'd0);
    chk("R5 held ack vec", 32'(vec_o), 32'(exp_vec[1]));
    ack_i = 1'b0;
    step();
    chk("R5 cleared after fall", 32'(irq_no), 32'd1);

    // R7: higher priority arrives during acknowledge
    pulse_req(4'b0100);
    ack_i = 1'b1; #1;
    chk("R7 initial winner", 32'(vec_o), 32'(exp_vec[2]));
    pulse_req(4'b0001);
    chk("R7 takeover winner", 32'(vec_o), 32'(exp_vec[0]));
    step();
    ack_i = 1'b0;
    step();
    chk("R7 loser still pending", 32'(irq_no), 32'd0);
    serve(2, "R7 loser served next");
    chk("R7 drained", 32'(irq_no), 32'd1);

    // R6: request held across clearing edge
    req_i = 4'b1000;
    step();
    ack_i = 1'b1;
    step();
    ack_i = 1'b0;
    step();
    chk("R6 line high one cycle at clear", 32'(irq_no), 32'd1);
    step();
    chk("R6 relatched held request", 32'(irq_no), 32'd0);
    req_i = '0;
    serve(3, "R6 relatched served");
    chk("R6 drained", 32'(irq_no), 32'd1);

    // R8: write without enable ignored, then real write
    cfg_we_i = 1'b0; cfg_idx_i = 2'd1; cfg_vec_i = 8'h99;
    step();
    pulse_req(4'b0010);
    serve(1, "R8 no write without enable");
    write_vec(1, 8'hEE);
    pulse_req(4'b0010);
    serve(1, "R8 new vector");

    // R9: reset while pending clears flags and vectors
    pulse_req(4'b0001);
    rst_ni = 1'b0; #1;
    chk("R9 reset clears pending", 32'(irq_no), 32'd1);
    step();
    rst_ni = 1'b1;
    step();
    pulse_req(4'b0100);
    ack_i = 1'b1; #1;
    chk("R9 vector zero after reset", 32'(vec_o), 32'd0);
    chk("R9 valid after reset", 32'(vec_valid_o), 32'd1);
    step();
    ack_i = 1'b0;
    step();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule